// File: doc/BRIEF.md
# Serial Keystream Tag Accumulator

This block builds a 64-bit authentication tag one message bit at a time. It holds two 64-bit words, an accumulator and a window register. A setup phase fills both words from a serial pseudo-random stream. The block receives 128 consecutive stream bits. The first 64 go into the accumulator and the next 64 go into the window register, each word filling from bit 0 upward.

After setup, every message step supplies one message bit and one fresh stream bit, taken from the odd-indexed positions of the generator output. When the message bit is 1, the accumulator absorbs the current window by XOR. The window then moves one place toward bit 0 and takes the stream bit at its top. The caller appends a single 1 as the padding bit and processes it like any other bit. A finalize request then freezes the accumulator and publishes it as the tag. Further message steps have no effect until a new setup begins.

Top module: `mac_tag_acc`

## Requirements
- R1: While reset is held and after reset releases, tag_valid_o is 0 and tag_o is all zeros.
- R2: During setup, load beat j for j = 0..63 sets accumulator bit j. With no message bits, the tag after finalize equals those 64 beats, with beat 0 in tag bit 0.
- R3: During setup, load beat 64+j for j = 0..63 sets window bit j. Setup ends on the 128th beat.
- R4: For a message step with message bit 1, the accumulator becomes its old value XOR the window as it stood before that step. A message bit of 0 leaves the accumulator unchanged.
- R5: On every message step the window shifts one place toward bit 0, and the step's stream bit enters at bit 63.
- R6: Message steps and finalize requests before the first setup completes, or during a setup, have no effect.
- R7: A finalize request after setup raises tag_valid_o on the next clock edge, and tag_o then shows the accumulator. tag_o reads zero while tag_valid_o is 0.
- R8: Once the tag is valid, message steps are ignored and the tag holds. A load beat clears tag_valid_o and starts a new 128-beat setup.
- R9: A load beat in the same cycle as a message step takes priority, and the message step is dropped.
- R10: Ending with a 1 followed by seven 0 message bits gives the same tag as ending with the single 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_valid_i | input | 1 | Setup beat strobe |
| load_bit_i | input | 1 | Setup stream bit |
| msg_valid_i | input | 1 | Message step strobe |
| msg_bit_i | input | 1 | Message bit |
| ks_bit_i | input | 1 | Odd-indexed stream bit for the current message step |
| fin_i | input | 1 | Finalize request |
| tag_o | output | 64 | Tag, zero until valid |
| tag_valid_o | output | 1 | Tag valid |

## Verification
The window register has no output of its own, so its contents are visible only through the tag. The hardest case is checking the setup fill of the window (R3) and its shifting (R5). The stimulus sends long runs of message bits that mix ones and zeros. Each 1 folds a different shifted window into the accumulator, and the bench model has to agree at finalize. Setups that start from the valid-tag state or during a running message, and load beats that collide with message steps, exercise the restart and priority paths.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned TAG_W = 64;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_RUN  = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/mac_seq.sv
module mac_seq
  import mac_pkg::*;
#(
  parameter int unsigned W = TAG_W
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_valid_i,
  input  logic   msg_valid_i,
  input  logic   fin_i,
  output phase_e phase_o,
  output logic   acc_ld_o,
  output logic   win_ld_o,
  output logic   msg_en_o
);
  localparam int unsigned LOAD_N = 2 * W;
  localparam int unsigned CNT_W  = $clog2(LOAD_N);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             start;

  assign start    = load_valid_i && (phase_q != PH_LOAD);
  assign idx      = start ? '0 : cnt_q;
  assign acc_ld_o = load_valid_i && (idx < CNT_W'(W));
  assign win_ld_o = load_valid_i && (idx >= CNT_W'(W));
  assign msg_en_o = (phase_q == PH_RUN) && msg_valid_i && !load_valid_i;

  always_comb begin
    phase_d = phase_q;
    if (load_valid_i)
      phase_d = (idx == CNT_W'(LOAD_N - 1)) ? PH_RUN : PH_LOAD;
    else if (phase_q == PH_RUN && fin_i)
      phase_d = PH_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (load_valid_i) cnt_q <= idx + CNT_W'(1);
    end
  end

  assign phase_o = phase_q;

  a_r3_load_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LOAD && load_valid_i && cnt_q == CNT_W'(LOAD_N - 1)) |=> (phase_q == PH_RUN));
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE && load_valid_i) |=> (phase_q == PH_LOAD));
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !load_valid_i) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         ld_bit_i,
  input  logic         msg_en_i,
  input  logic         msg_bit_i,
  input  logic [W-1:0] win_i,
  output logic [W-1:0] acc_o
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   acc_q <= '0;
    else if (ld_i)                 acc_q <= {ld_bit_i, acc_q[W-1:1]};
    else if (msg_en_i && msg_bit_i) acc_q <= acc_q ^ win_i;
  end

  assign acc_o = acc_q;

  a_r4_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_en_i && !msg_bit_i && !ld_i) |=> $stable(acc_q));
endmodule

// File: rtl/mac_win.sv
module mac_win #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         ld_bit_i,
  input  logic         step_i,
  input  logic         ks_bit_i,
  output logic [W-1:0] win_o
);
  logic [W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_q <= '0;
    else if (ld_i)   win_q <= {ld_bit_i, win_q[W-1:1]};
    else if (step_i) win_q <= {ks_bit_i, win_q[W-1:1]};
  end

  assign win_o = win_q;

  a_r5_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (win_q[W-2:0] == $past(win_q[W-1:1])) && (win_q[W-1] == $past(ks_bit_i)));
endmodule

// File: rtl/mac_tag_acc.sv
module mac_tag_acc
  import mac_pkg::*;
#(
  parameter int unsigned W = TAG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_valid_i,
  input  logic         load_bit_i,
  input  logic         msg_valid_i,
  input  logic         msg_bit_i,
  input  logic         ks_bit_i,
  input  logic         fin_i,
  output logic [W-1:0] tag_o,
  output logic         tag_valid_o
);
  phase_e       phase;
  logic         acc_ld, win_ld, msg_en;
  logic [W-1:0] acc, win;

  mac_seq #(.W(W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_valid_i(load_valid_i),
    .msg_valid_i(msg_valid_i), .fin_i(fin_i), .phase_o(phase),
    .acc_ld_o(acc_ld), .win_ld_o(win_ld), .msg_en_o(msg_en)
  );

  mac_acc #(.W(W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(acc_ld), .ld_bit_i(load_bit_i),
    .msg_en_i(msg_en), .msg_bit_i(msg_bit_i), .win_i(win), .acc_o(acc)
  );

  mac_win #(.W(W)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(win_ld), .ld_bit_i(load_bit_i),
    .step_i(msg_en), .ks_bit_i(ks_bit_i), .win_o(win)
  );

  assign tag_valid_o = (phase == PH_DONE);
  assign tag_o       = tag_valid_o ? acc : '0;

  a_r8_tag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_valid_o && !load_valid_i) |=> (tag_valid_o && $stable(tag_o)));
  a_r7_fin_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_RUN && fin_i && !load_valid_i) |=> tag_valid_o);
endmodule

// File: tb/mac_tag_acc_tb.sv
module mac_tag_acc_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        lv = 0, lb = 0, mv = 0, mb = 0, ks = 0, fin = 0;
  logic [63:0] tag;
  logic        tag_v;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [63:0] m_acc = '0;
  bit          m_win[$];
  int          m_ph = 0, m_cnt = 0;
  logic [63:0] saved_tag;

  always #10 clk = ~clk;

  mac_tag_acc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_valid_i(lv), .load_bit_i(lb),
    .msg_valid_i(mv), .msg_bit_i(mb), .ks_bit_i(ks), .fin_i(fin),
    .tag_o(tag), .tag_valid_o(tag_v)
  );

  function automatic logic [63:0] pack_win();
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++) r[i] = m_win[i];
    return r;
  endfunction

  task automatic model();
    if (lv) begin
      if (m_ph != 1) begin m_ph = 1; m_cnt = 0; m_win.delete(); end
      if (m_cnt < 64) m_acc[m_cnt] = lb; else m_win.push_back(lb);
      m_cnt++;
      if (m_cnt == 128) m_ph = 2;
    end else if (m_ph == 2) begin
      if (mv) begin
        if (mb) m_acc ^= pack_win();
        void'(m_win.pop_front());
        m_win.push_back(ks);
      end
      if (fin) m_ph = 3;
    end
  endtask

  task automatic check(string req);
    logic        ev = (m_ph == 3);
    logic [63:0] et = ev ? m_acc : '0;
    n_tests++;
    if (tag_v !== ev || tag !== et) begin
      n_fail++;
      $display("FAIL %s: tag_valid=%0b tag=%h expected tag_valid=%0b tag=%h", req, tag_v, tag, ev, et);
    end
  endtask

  task automatic step(bit l, bit lbit, bit m, bit mbit, bit k, bit f, string req);
    lv = l; lb = lbit; mv = m; mb = mbit; ks = k; fin = f;
    @(posedge clk); #5;
    model();
    check(req);
    lv = 0; mv = 0; fin = 0;
  endtask

  task automatic do_load(logic [127:0] pat, string req);
    for (int i = 0; i < 128; i++) step(1, pat[i], 0, 0, 0, 0, req);
  endtask

  task automatic do_msgs(int n, int seed, string req);
    for (int i = 0; i < n; i++) step(0, 0, 1, (i * 7 + seed) % 3 == 0, (i * 5 + seed) % 2, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 check("R1 in reset");
    @(negedge clk) rst_n = 1;
    #5 check("R1 after reset");

    // R6: activity before any setup
    step(0, 0, 1, 1, 1, 0, "R6 msg before setup");
    step(0, 0, 0, 0, 0, 1, "R6 fin before setup");

    // R2: setup then finalize straight away
    do_load({64'hFFFF_0000_A5A5_5A5A, 64'h8000_0000_0000_0001}, "R2 load");
    step(0, 0, 0, 0, 0, 1, "R2 tag is accumulator fill");

    // R8: message ignored while tag valid
    step(0, 0, 1, 1, 1, 0, "R8 msg ignored after fin");
    step(0, 0, 1, 1, 0, 0, "R8 tag holds");

    // R3/R4: new setup from the valid state, single 1 folds the window
    do_load({64'h0123_4567_89AB_CDEF, 64'h0}, "R3 restart load");
    step(0, 0, 1, 1, 0, 0, "R3 window folded");
    step(0, 0, 0, 0, 0, 1, "R3 fin");

    // R6: message/fin during setup ignored
    for (int i = 0; i < 60; i++) step(1, i[0], 0, 0, 0, 0, "R6 load part");
    step(0, 0, 1, 1, 1, 1, "R6 msg during setup");
    for (int i = 60; i < 128; i++) step(1, i[1], 0, 0, 0, 0, "R6 load rest");

    // R4/R5: long mixed message
    do_msgs(150, 1, "R5 message run");
    step(0, 0, 0, 0, 0, 1, "R4 fin after run");

    // R9: load collides with message
    do_load({64'hDEAD_BEEF_0BAD_F00D, 64'h1357_9BDF_2468_ACE0}, "R9 load");
    do_msgs(10, 2, "R9 msgs");
    step(1, 1, 1, 1, 1, 0, "R9 load wins over msg");
    for (int i = 1; i < 128; i++) step(1, i[2], 1, 1, 1, 0, "R9 colliding beats");
    do_msgs(40, 3, "R9 post msgs");
    step(0, 0, 0, 0, 0, 1, "R9 fin");

    // R10: padding forms
    do_load({64'hCAFE_F00D_1234_5678, 64'h9ABC_DEF0_0F1E_2D3C}, "R10 load a");
    do_msgs(20, 4, "R10 body a");
    step(0, 0, 1, 1, 1, 0, "R10 pad a");
    step(0, 0, 0, 0, 0, 1, "R10 fin a");
    saved_tag = tag;
    do_load({64'hCAFE_F00D_1234_5678, 64'h9ABC_DEF0_0F1E_2D3C}, "R10 load b");
    do_msgs(20, 4, "R10 body b");
    step(0, 0, 1, 1, 1, 0, "R10 pad b");
    for (int i = 0; i < 7; i++) step(0, 0, 1, 0, i[0], 0, "R10 pad zeros");
    step(0, 0, 0, 0, 0, 1, "R10 fin b");
    n_tests++;
    if (tag !== saved_tag) begin
      n_fail++;
      $display("FAIL R10 byte pad tag=%h expected %h", tag, saved_tag);
    end

    // R7: fin with a message step in the same cycle
    do_load({64'h1, 64'h2}, "R7 load");
    do_msgs(5, 5, "R7 msgs");
    step(0, 0, 1, 1, 1, 1, "R7 fin with msg");
    step(0, 0, 0, 0, 0, 0, "R7 hold");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule